// File: doc/BRIEF.md
# Sequential Keypad Combination Lock

This block turns ten raw push-button levels into a lock decision. Four of the buttons are code keys that have to be pressed in a fixed order. Each code key drives one single-bit stage of a four-stage progress chain. On a press of its own key, a stage takes the value of the stage before it, and the first stage always takes a 1. Pressing the keys in the right order therefore sets the chain from the bottom up, and any press out of order earns nothing.

Five of the remaining buttons are decoy keys. A press of any of them throws away the partial progress. The sixth is a dedicated relock key, and it is the only way out of the unlocked state. When the last stage sets, the unlock output goes high and the three lower stages are cleared and held clear. After that, any number of further code presses, whether deliberate or caused by contact bounce, leave the lock unlocked.

Every button first passes through a two-flop synchroniser. It then goes through a debouncer whose stable-count is a parameter, and finally through a rising-edge detector. As a result, one physical press gives at most one event.

Top module: `keypad_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the lock is placed locked: `unlocked` = 0 and `progress` = 4'b0000.
- R2: Clean presses of `code_key[0]`, `[1]`, `[2]`, `[3]` in that order give `progress` of 4'b0001, 4'b0011, 4'b0111 and then 4'b1000 with `unlocked` = 1. Bit k of `progress` is stage k+1, and bit 3 equals `unlocked`.
- R3: A press of `code_key[k]` with k > 0 while `progress[k-1]` is 0 leaves `progress[k]` at 0.
- R4: A press of any `wrong_key` bit clears `progress[2:0]` to 0 and leaves `unlocked` unchanged.
- R5: While unlocked, presses of any code key, including bouncing presses of `code_key[3]`, leave `progress` at 4'b1000.
- R6: A press of `reset_key` clears every stage, so `progress` = 4'b0000 and `unlocked` = 0. No other key clears `unlocked`.
- R7: A button level held for fewer than `DB_CYCLES` clocks has no effect. A press that bounces, with no gap as long as `DB_CYCLES`, counts as one press, and the level returning low produces no event.
- R8: When a decoy or relock event falls in the same cycle as a code event, the clearing event wins and no stage advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| code_key | input | 4 | Raw levels of the code buttons, 1 = pressed; bit k drives stage k+1 |
| wrong_key | input | 5 | Raw levels of the decoy buttons, 1 = pressed |
| reset_key | input | 1 | Raw level of the relock button, 1 = pressed |
| unlocked | output | 1 | High while the final stage is set |
| progress | output | 4 | Stage state, bit 3 = final stage |

## Verification
The bound checker examines the event pulses between the conditioners and the chain on every cycle. It checks the following:
- A clearing event always empties the lower stages.
- A stage never rises unless its predecessor was already set.
- The unlock only drops after a relock event.
- While unlocked, the lower stages stay clear.

Only the bench's scenarios can show the debounce behaviour, because it depends on how long a raw level is held. The same applies to how presses are ordered across a whole code entry. The bench covers these with short glitches, bounce trains, out-of-order sequences and simultaneous presses, against a cycle-level model.

// File: rtl/lock_pkg.sv
// Package: shared constants and the key-event bundle for the keypad lock.
// Assumes: the code length and decoy count are fixed by the keypad layout.
package lock_pkg;
    localparam int unsigned CODE_LEN   = 4;
    localparam int unsigned DECOY_KEYS = 5;
    localparam int unsigned ALL_KEYS   = CODE_LEN + DECOY_KEYS + 1;

    // Conditioned one-cycle events, as seen by the progress chain.
    typedef struct packed {
        logic                  relock;
        logic                  decoy;
        logic [CODE_LEN-1:0]   code;
    } key_events_t;
endpackage

// File: rtl/key_sync.sv
// key_sync: two-flop synchroniser for one asynchronous button level.
// Assumes: the input may change at any time relative to clk.
module key_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic sync_out
);
    logic meta_q;
    logic sync_q;

    // Two-stage resynchronisation into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/key_debounce.sv
// key_debounce: accepts a new level only after it has differed from the
// accepted level for DB_CYCLES consecutive clocks, then emits a one-cycle
// pulse on each accepted low-to-high change.
// Assumes: input is already synchronous to clk.
module key_debounce #(
    parameter int unsigned DB_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic press_pulse
);
    localparam int unsigned CW = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

    logic [CW-1:0] run_cnt;
    logic          level_q;
    logic          level_d;

    // Count consecutive disagreeing cycles and accept the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level_q <= 1'b0;
        end else if (level_in != level_q) begin
            if (run_cnt == LAST) begin
                level_q <= level_in;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    // Delayed copy of the accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level_q;
    end

    assign press_pulse = level_q & ~level_d;
endmodule

// File: rtl/lock_chain.sv
// lock_chain: the progress stages. Stage k loads its predecessor (stage 0
// loads 1) on its own code event. Reaching the last stage clears the rest,
// and the last stage then ignores all code events until a relock event.
// Decoy and relock events win over code events in the same cycle.
// Assumes: every event input is a one-cycle pulse.
module lock_chain
    import lock_pkg::*;
#(
    parameter int unsigned STAGES = CODE_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] code_evt,
    input  logic              decoy_evt,
    input  logic              relock_evt,
    output logic [STAGES-1:0] stage_q
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] loaded;
    logic [STAGES-1:0] stage_nxt;

    // Per-stage load: first stage takes 1, the others their predecessor.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign loaded[k] = code_evt[k] ? 1'b1 : stage_q[k];
        end else begin : g_next
            assign loaded[k] = code_evt[k] ? stage_q[k-1] : stage_q[k];
        end
    end

    // Unlocking clears all lower stages in the same step.
    always_comb begin
        stage_nxt = loaded;
        if (loaded[TOP]) stage_nxt[TOP-1:0] = '0;
    end

    // Stage register update with clear priority and unlocked freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (decoy_evt || relock_evt) begin
            stage_q[TOP-1:0] <= '0;
            if (relock_evt) stage_q[TOP] <= 1'b0;
        end else if (!stage_q[TOP]) begin
            stage_q <= stage_nxt;
        end
    end
endmodule

// File: rtl/keypad_lock.sv
// keypad_lock: top level. Conditions all buttons (synchronise, debounce,
// edge-detect) and feeds the resulting events into the progress chain.
// Assumes: buttons are active-high raw levels; rst_n is synchronous.
module keypad_lock
    import lock_pkg::*;
#(
    parameter int unsigned DB_CYCLES = 50000,
    parameter int unsigned N_CODE    = CODE_LEN,
    parameter int unsigned N_DECOY   = DECOY_KEYS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CODE-1:0]  code_key,
    input  logic [N_DECOY-1:0] wrong_key,
    input  logic               reset_key,
    output logic               unlocked,
    output logic [N_CODE-1:0]  progress
);
    localparam int unsigned N_KEYS = N_CODE + N_DECOY + 1;

    logic [N_KEYS-1:0]  raw_keys;
    logic [N_KEYS-1:0]  sync_keys;
    logic [N_KEYS-1:0]  key_pulse;
    logic [N_CODE-1:0]  code_pulse;
    logic               wrong_pulse;
    logic               reset_pulse;
    logic [N_CODE-1:0]  stages;

    assign raw_keys = {reset_key, wrong_key, code_key};

    // One conditioner per button.
    for (genvar i = 0; i < N_KEYS; i++) begin : g_key
        key_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_keys[i]),
            .sync_out (sync_keys[i])
        );
        key_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
            .clk         (clk),
            .rst_n       (rst_n),
            .level_in    (sync_keys[i]),
            .press_pulse (key_pulse[i])
        );
    end

    assign code_pulse  = key_pulse[N_CODE-1:0];
    assign wrong_pulse = |key_pulse[N_CODE+N_DECOY-1:N_CODE];
    assign reset_pulse = key_pulse[N_KEYS-1];

    lock_chain #(.STAGES(N_CODE)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_evt   (code_pulse),
        .decoy_evt  (wrong_pulse),
        .relock_evt (reset_pulse),
        .stage_q    (stages)
    );

    assign progress = stages;
    assign unlocked = stages[N_CODE-1];
endmodule

// File: rtl/keypad_lock_checker.sv
// keypad_lock_checker: temporal properties of the lock, bound to the top.
module keypad_lock_checker #(
    parameter int unsigned N_CODE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CODE-1:0] progress,
    input logic [N_CODE-1:0] code_pulse,
    input logic              wrong_pulse,
    input logic              reset_pulse
);
    localparam int unsigned TOP = N_CODE - 1;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (progress == '0));

    assert_first_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(progress[0]) |-> $past(code_pulse[0]));

    for (genvar k = 1; k < N_CODE; k++) begin : g_order
        assert_no_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(progress[k]) |-> ($past(progress[k-1]) && $past(code_pulse[k])));
    end

    assert_decoy_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrong_pulse |=> (progress[TOP-1:0] == '0));

    assert_open_holds_lower_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        progress[TOP] |-> (progress[TOP-1:0] == '0));

    assert_stays_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (progress[TOP] && !reset_pulse) |=> progress[TOP]);

    assert_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> (progress == '0));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_pulse != '0) && (wrong_pulse || reset_pulse)) |=> (progress[TOP-1:0] == '0));
endmodule

bind keypad_lock keypad_lock_checker #(.N_CODE(N_CODE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .progress    (progress),
    .code_pulse  (code_pulse),
    .wrong_pulse (wrong_pulse),
    .reset_pulse (reset_pulse)
);

// File: tb/keypad_lock_bench.sv
module keypad_lock_bench;
    localparam int DB = 4;
    localparam int SETTLE = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] raw = '0;   // {reset, wrong[4:0], code[3:0]}
    logic       unlocked;
    logic [3:0] progress;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #10 clk = ~clk;   // 50 MHz

    keypad_lock #(.DB_CYCLES(DB)) u_keypad_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_key  (raw[3:0]),
        .wrong_key (raw[8:4]),
        .reset_key (raw[9]),
        .unlocked  (unlocked),
        .progress  (progress)
    );

    // Behavioural reference: per-key sample history, run counters, lock state.
    bit [9:0] m_s1, m_s2, m_lvl, m_lvl_d;
    int       m_run [10];
    bit [3:0] m_stage;

    always @(posedge clk) begin
        bit [9:0] ev;
        bit [3:0] nxt;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_lvl_d = '0; m_stage = '0;
            for (int i = 0; i < 10; i++) m_run[i] = 0;
        end else begin
            ev = m_lvl & ~m_lvl_d;
            if (ev[9] || (ev[8:4] != 0)) begin
                m_stage[2:0] = 0;
                if (ev[9]) m_stage[3] = 0;
            end else if (!m_stage[3]) begin
                nxt = m_stage;
                for (int k = 0; k < 4; k++)
                    if (ev[k]) nxt[k] = (k == 0) ? 1'b1 : m_stage[k-1];
                if (nxt[3]) nxt = 4'b1000;
                m_stage = nxt;
            end
            m_lvl_d = m_lvl;
            for (int i = 0; i < 10; i++) begin
                if (m_s2[i] != m_lvl[i]) begin
                    if (m_run[i] == DB - 1) begin m_lvl[i] = m_s2[i]; m_run[i] = 0; end
                    else m_run[i]++;
                end else m_run[i] = 0;
            end
            m_s2 = m_s1;
            m_s1 = raw;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (progress !== m_stage || unlocked !== m_stage[3]) begin
                misses++;
                $display("FAIL R2 cycle compare: progress=%b unlocked=%b expected %b",
                         progress, unlocked, m_stage);
            end
        end
    end

    task automatic check(input string req, input logic [3:0] exp);
        vectors++;
        if (progress !== exp || unlocked !== exp[3]) begin
            misses++;
            $display("FAIL %s: progress=%b unlocked=%b expected %b", req, progress, unlocked, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [9:0] m);
        @(negedge clk); raw = raw | m;
        wait_cyc(SETTLE);
        raw = raw & ~m;
        wait_cyc(SETTLE);
    endtask

    task automatic bouncy_press(input logic [9:0] m);
        @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            raw = raw | m;  wait_cyc(1);
            raw = raw & ~m; wait_cyc(1);
        end
        raw = raw | m; wait_cyc(SETTLE);
        for (int b = 0; b < 2; b++) begin
            raw = raw & ~m; wait_cyc(1);
            raw = raw | m;  wait_cyc(1);
        end
        raw = raw & ~m; wait_cyc(SETTLE);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            misses++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        check("R1 reset state", 4'b0000);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 after release", 4'b0000);

        press(10'h001); check("R2 first", 4'b0001);
        press(10'h002); check("R2 second", 4'b0011);
        press(10'h004); check("R2 third", 4'b0111);
        press(10'h008); check("R2 open", 4'b1000);

        press(10'h008);        check("R5 repeat last key", 4'b1000);
        bouncy_press(10'h008); check("R5 bouncing last key", 4'b1000);
        press(10'h001);        check("R5 first key while open", 4'b1000);
        press(10'h040);        check("R4 decoy keeps open", 4'b1000);
        press(10'h200);        check("R6 relock", 4'b0000);

        press(10'h002); check("R3 skip to second", 4'b0000);
        press(10'h001); check("R3 first", 4'b0001);
        press(10'h004); check("R3 skip to third", 4'b0001);
        press(10'h002); check("R3 second", 4'b0011);
        press(10'h100); check("R4 decoy clears", 4'b0000);

        @(negedge clk); raw = 10'h001; wait_cyc(2); raw = '0; wait_cyc(SETTLE);
        check("R7 short glitch", 4'b0000);
        bouncy_press(10'h001); check("R7 bounce first", 4'b0001);
        bouncy_press(10'h002); check("R7 bounce second", 4'b0011);

        press(10'h014); check("R8 code and decoy together", 4'b0000);
        press(10'h001); press(10'h002); press(10'h004);
        check("R8 setup", 4'b0111);
        press(10'h208); check("R8 relock beats last key", 4'b0000);

        rst_n = 1'b0; press(10'h001); check("R1 keys during reset", 4'b0000);
        rst_n = 1'b1; wait_cyc(4);

        finish_run();
    end
endmodule